// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Timing Model

This block stands in for a cache inside a cycle-level timing simulation. It keeps no line data, only a tag and a valid bit for every way of every set, plus a pseudo-LRU tree per set. Each accepted request names an address, which should be the physical one when both exist, and a read/write flag. One cycle later the block reports whether the access hit, which way it used, and the flag it was given. On a miss the line is allocated at once in the way the pseudo-LRU tree selects. Running counts of accesses, hits and misses are kept in hardware for the statistics side of the simulator.

The cache geometry comes from parameters alone. The default is 32 KB, 4 ways and 16-byte lines, which gives 512 sets. Setting 2 MB capacity and 64-byte lines gives 8192 sets with no other change. A flush pulse, and reset as well, starts a sweep that invalidates one set per cycle. No request is taken while the sweep runs.

Top module: `cache_tag_timer`

## Requirements
- R1: The number of sets is CACHE_BYTES/(WAYS*LINE_BYTES). Address bits [log2(LINE_BYTES)-1:0] are ignored. The next log2(sets) bits select the set, and all the remaining upper bits form the tag.
- R2: A request hits when the selected set holds a valid way whose tag matches. The result then shows res_hit=1 and, on res_way, the number of that way.
- R3: On a miss the block allocates the way chosen by the pseudo-LRU tree, reports res_hit=0 with that way on res_way, and marks the way valid with the new tag. A following access to the same line hits in that way.
- R4: Each set keeps a tree of WAYS-1 bits. Every hit and every fill turns each node on the path to the way just used so that it points away from that way. In a freshly cleared 4-way set, four distinct lines land in ways 0, 2, 1, 3 in that order. Once way 0 is touched again, the next miss replaces way 2.
- R5: Writes are looked up and allocated exactly like reads. The request's write flag is returned on res_write with its result.
- R6: A request is accepted in a cycle where req_valid and req_ready are both high. Its result appears with res_valid high exactly one cycle later. Back-to-back requests are accepted every cycle, and each one sees the tag and tree updates made by the one before it. res_valid is low in every cycle that follows a cycle with no acceptance.
- R7: A one-cycle flush pulse, given while no sweep is running, starts a sweep that clears the valid bits and the tree bits of one set per cycle. req_ready is low for exactly as many cycles as there are sets. Every line present before the flush misses afterwards.
- R8: Synchronous active-high reset clears res_valid and all counters and starts the same sweep. req_ready stays low for as many cycles as there are sets after reset is released.
- R9: The access, hit and miss counters are CNT_W bits wide (default 32). Each accepted request adds one to the access counter and one to either the hit or the miss counter, at the same edge that produces its result. A counter at its maximum value stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pulse that starts an invalidate sweep |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (low while sweeping) |
| req_addr | input | ADDR_W | Access address (physical when available) |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| res_hit | output | 1 | 1 for a hit, 0 for a miss |
| res_way | output | log2(WAYS) | Way that hit or was filled |
| res_write | output | 1 | Write flag of the request being reported |
| cnt_access | output | CNT_W | Saturating count of accepted requests |
| cnt_hit | output | CNT_W | Saturating count of hits |
| cnt_miss | output | CNT_W | Saturating count of misses |

## Verification
The bench builds the block with 16-bit addresses, 256 bytes of capacity, 4 ways and 16-byte lines, which gives 4 sets of 4 ways. A single set can therefore be filled, overflowed and made to evict within a handful of accesses. Each reset or flush sweep lasts only four cycles, so its stall length can be counted exactly. The counters are built 5 bits wide, so the access and hit counters reach their saturation value of 31 in a short run of repeated hits.

// File: rtl/tct_pkg.sv
package tct_pkg;

  // Kind of event a lookup produces; used by the statistics path.
  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_HIT  = 2'd1,
    EV_MISS = 2'd2
  } lookup_ev_e;

endpackage

// File: rtl/tct_plru_logic.sv
// Tree pseudo-LRU: victim selection and update for one set.
// A node bit of 0 steers the victim search to the lower half.
module tct_plru_logic #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [NODES-1:0] tree_i,
  input  logic [WAY_W-1:0] used_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [NODES-1:0] tree_o
);

  always_comb begin
    int unsigned node;
    logic        dir;
    node     = 0;
    victim_o = '0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir = tree_i[node];
      victim_o[WAY_W-1-lvl] = dir;
      node = 2 * node + 1 + {31'd0, dir};
    end
  end

  always_comb begin
    int unsigned node;
    logic        dir;
    node   = 0;
    tree_o = tree_i;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir = used_way_i[WAY_W-1-lvl];
      tree_o[node] = ~dir;
      node = 2 * node + 1 + {31'd0, dir};
    end
  end

endmodule

// File: rtl/tct_way_bank.sv
// Tag and valid storage for one way across all sets.
module tct_way_bank #(
  parameter int SETS  = 512,
  parameter int TAG_W = 19,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             fill_en_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i
);

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (fill_en_i) tag_mem[lk_idx_i] <= lk_tag_i;
  end

  // Clearing takes priority; the sweep starts at reset so no reset here.
  always_ff @(posedge clk) begin
    if (clr_en_i)       vld_q[clr_idx_i] <= 1'b0;
    else if (fill_en_i) vld_q[lk_idx_i]  <= 1'b1;
  end

  assign hit_o = vld_q[lk_idx_i] && (tag_mem[lk_idx_i] == lk_tag_i);

  // R7: a set visited by the sweep is invalid on the next cycle.
  a_r7_set_cleared: assert property (@(posedge clk)
    clr_en_i |=> !vld_q[$past(clr_idx_i)]);

endmodule

// File: rtl/tct_sat_counter.sv
// Saturating event counter with synchronous clear.
module tct_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst)                         cnt_o <= '0;
    else if (inc_i && (cnt_o != '1)) cnt_o <= cnt_o + 1'b1;
  end

  // R9: once saturated, the counter holds.
  a_r9_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '1) |=> (cnt_o == '1));

  // R9: never more than one step per cycle, never backwards.
  a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));

endmodule

// File: rtl/cache_tag_timer.sv
// Tag-only set-associative cache timing model (top).
module cache_tag_timer #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 32768,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int CNT_W       = 32,
  localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              res_valid,
  output logic              res_hit,
  output logic [WAY_W-1:0]  res_way,
  output logic              res_write,
  output logic [CNT_W-1:0]  cnt_access,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import tct_pkg::*;

  // ---------------- address split ----------------
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  assign lk_idx = req_addr[OFF_W +: IDX_W];
  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];

  // ---------------- sweep (reset / flush) ----------------
  logic             sweep_q;
  logic [IDX_W-1:0] sweep_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_q     <= 1'b1;
      sweep_idx_q <= '0;
    end else if (sweep_q) begin
      if (sweep_idx_q == IDX_W'(SETS - 1)) begin
        sweep_q     <= 1'b0;
        sweep_idx_q <= '0;
      end else begin
        sweep_idx_q <= sweep_idx_q + 1'b1;
      end
    end else if (flush) begin
      sweep_q     <= 1'b1;
      sweep_idx_q <= '0;
    end
  end

  assign req_ready = !sweep_q;

  logic accept;
  assign accept = req_valid && req_ready;

  // ---------------- tag lookup ----------------
  logic [WAYS-1:0]  way_hit;
  logic [WAY_W-1:0] victim;
  logic             any_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic fill_en;
    assign fill_en = accept && !any_hit && (victim == WAY_W'(w));
    tct_way_bank #(
      .SETS  (SETS),
      .TAG_W (TAG_W)
    ) u_bank (
      .clk       (clk),
      .lk_idx_i  (lk_idx),
      .lk_tag_i  (lk_tag),
      .hit_o     (way_hit[w]),
      .fill_en_i (fill_en),
      .clr_en_i  (sweep_q),
      .clr_idx_i (sweep_idx_q)
    );
  end

  assign any_hit = |way_hit;

  logic [WAY_W-1:0] hit_way;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  // ---------------- pseudo-LRU ----------------
  logic [NODES-1:0] plru_mem [SETS];
  logic [NODES-1:0] tree_cur;
  logic [NODES-1:0] tree_next;
  logic [WAY_W-1:0] used_way;

  assign tree_cur = plru_mem[lk_idx];
  assign used_way = any_hit ? hit_way : victim;

  tct_plru_logic #(
    .WAYS (WAYS)
  ) u_plru (
    .tree_i     (tree_cur),
    .used_way_i (used_way),
    .victim_o   (victim),
    .tree_o     (tree_next)
  );

  always_ff @(posedge clk) begin
    if (sweep_q)     plru_mem[sweep_idx_q] <= '0;
    else if (accept) plru_mem[lk_idx]      <= tree_next;
  end

  // ---------------- result register ----------------
  lookup_ev_e ev;
  always_comb begin
    if (!accept)      ev = EV_IDLE;
    else if (any_hit) ev = EV_HIT;
    else              ev = EV_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_way   <= '0;
      res_write <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_hit   <= (ev == EV_HIT);
        res_way   <= used_way;
        res_write <= req_write;
      end
    end
  end

  // ---------------- statistics ----------------
  tct_sat_counter #(.CNT_W(CNT_W)) u_cnt_access (
    .clk (clk), .rst (rst), .inc_i (ev != EV_IDLE), .cnt_o (cnt_access)
  );
  tct_sat_counter #(.CNT_W(CNT_W)) u_cnt_hit (
    .clk (clk), .rst (rst), .inc_i (ev == EV_HIT), .cnt_o (cnt_hit)
  );
  tct_sat_counter #(.CNT_W(CNT_W)) u_cnt_miss (
    .clk (clk), .rst (rst), .inc_i (ev == EV_MISS), .cnt_o (cnt_miss)
  );

  // ---------------- assertions ----------------
  // R2: at most one way of a set matches a given tag.
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    accept |-> $onehot0(way_hit));

  // R6: each acceptance yields a result on the next cycle.
  a_r6_result_follows: assert property (@(posedge clk) disable iff (rst)
    accept |=> res_valid);

  // R6: no result without an acceptance one cycle earlier.
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !res_valid);

  // R7: while stalled nothing is reported on the next cycle.
  a_r7_stall_silent: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> !res_valid);

  // R8: the first cycle after reset release is a stall.
  a_r8_stall_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !req_ready);

  // R9: the hit count never exceeds the access count.
  a_r9_hits_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_hit <= cnt_access);

endmodule

// File: tb/cache_tag_timer_tb.sv
module cache_tag_timer_tb;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int WAYS   = 4;
  localparam int SETS   = 4;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              res_valid;
  logic              res_hit;
  logic [1:0]        res_way;
  logic              res_write;
  logic [CNT_W-1:0]  cnt_access;
  logic [CNT_W-1:0]  cnt_hit;
  logic [CNT_W-1:0]  cnt_miss;

  always #(CLK_P/2) clk = ~clk;

  cache_tag_timer #(
    .ADDR_W      (ADDR_W),
    .CACHE_BYTES (256),
    .WAYS        (WAYS),
    .LINE_BYTES  (16),
    .CNT_W       (CNT_W)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_way    (res_way),
    .res_write  (res_write),
    .cnt_access (cnt_access),
    .cnt_hit    (cnt_hit),
    .cnt_miss   (cnt_miss)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [3:0] exp_q [$];   // {hit, way[1:0], write}
  string      tag_q [$];

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Address layout: tag [15:6], set [5:4], byte offset [3:0] (R1).
  function automatic logic [ADDR_W-1:0] mk(input int tg, input int st, input int off);
    return {tg[9:0], st[1:0], off[3:0]};
  endfunction

  // Driver: present one request, push its expected result.
  task automatic issue(input int tg, input int st, input int off, input bit wr,
                       input bit e_hit, input int e_way, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk(tg, st, off);
    req_write = wr;
    exp_q.push_back({e_hit, e_way[1:0], wr});
    tag_q.push_back(rq);
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic check_counts(input int a, input int h, input int m, input string rq);
    #1;
    check(int'(cnt_access) == a, rq, "access count", int'(cnt_access), a);
    check(int'(cnt_hit)    == h, rq, "hit count",    int'(cnt_hit),    h);
    check(int'(cnt_miss)   == m, rq, "miss count",   int'(cnt_miss),   m);
  endtask

  // Monitor: compare each result against the scoreboard.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected result", 1, 0);
      end else begin
        logic [3:0] e;
        string      rq;
        e  = exp_q.pop_front();
        rq = tag_q.pop_front();
        check(res_hit == e[3], rq, "res_hit", int'(res_hit), int'(e[3]));
        if (res_hit == e[3])
          check(res_way == e[2:1], rq, "res_way", int'(res_way), int'(e[2:1]));
        check(res_write == e[0], {rq, "/R5"}, "res_write", int'(res_write), int'(e[0]));
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    // ---- reset (R8) ----
    repeat (3) @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R8", "res_valid in reset", int'(res_valid), 0);
    check(req_ready == 1'b0, "R8", "ready in reset", int'(req_ready), 0);
    check_counts(0, 0, 0, "R8");
    @(negedge clk);
    rst = 1'b0;
    #1;
    n = 0;
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    check(n == SETS, "R8", "stall cycles after reset", n, SETS);

    // ---- fill and evict in set 0 (R1..R6, back-to-back) ----
    issue(1, 0, 0, 1'b0, 1'b0, 0, "R3");      // cold miss -> way 0
    issue(1, 0, 4, 1'b0, 1'b1, 0, "R1");      // offset ignored, hit way 0
    issue(2, 0, 0, 1'b1, 1'b0, 2, "R4");      // write miss -> way 2
    issue(3, 0, 8, 1'b0, 1'b0, 1, "R4");      // -> way 1
    issue(4, 0, 0, 1'b0, 1'b0, 3, "R4");      // -> way 3
    issue(1, 0, 0, 1'b1, 1'b1, 0, "R2");      // write hit way 0
    issue(5, 0, 0, 1'b0, 1'b0, 2, "R4");      // evicts way 2
    issue(2, 0, 0, 1'b0, 1'b0, 1, "R3");      // line 2 gone; evicts way 1
    issue(1, 0, 15, 1'b0, 1'b1, 0, "R2");     // still in way 0
    issue(1, 1, 0, 1'b0, 1'b0, 0, "R1");      // other set: cold miss way 0
    issue(1, 1, 0, 1'b0, 1'b1, 0, "R6");      // back-to-back hit
    go_idle();
    check_counts(11, 4, 7, "R9");
    @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R6", "res_valid when idle", int'(res_valid), 0);
    check(exp_q.size() == 0, "R6", "pending results", exp_q.size(), 0);

    // ---- flush (R7) ----
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    @(negedge clk);
    #1;
    n = 0;
    while (!req_ready && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
    check(n == SETS, "R7", "stall cycles during flush", n, SETS);
    issue(1, 0, 0, 1'b0, 1'b0, 0, "R7");      // previously present, now misses
    go_idle();
    check_counts(12, 4, 8, "R7");

    // ---- saturation (R9) ----
    for (int i = 0; i < 25; i++) issue(1, 0, 0, 1'b0, 1'b1, 0, "R9");
    go_idle();
    check_counts(31, 29, 8, "R9");
    for (int i = 0; i < 5; i++) issue(1, 0, 0, 1'b0, 1'b1, 0, "R9");
    go_idle();
    check_counts(31, 31, 8, "R9");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6", "results outstanding at end", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule